// File: doc/BRIEF.md
# Thermometer-Coded Octal Token Counter

This block holds a prepaid token balance as five octal digits. Each digit is stored as a run of ones. The value of a digit is the number of ones in its field. The balance is D4·4096 + D3·512 + D2·64 + D1·8 + D0. The top digit has a 7-bit field and holds at most seven. Each of the other four digits has an 8-bit field and holds at most eight. The value eight is needed so that a digit can take a borrow from the digit above it.

A bit-address input selects one bit inside a digit field. The block returns that bit on a combinational read-out line, together with a flag that is high when the digit under the address is zero. Three command strobes change the balance:
- a single-step decrement of the addressed digit;
- a borrow that refills the next lower digit to eight;
- a combined decrement-and-borrow.

The combined command is held in a staging register. It reaches the digit storage only when a done pulse commits it. An abort throws it away, so an interrupted combined update leaves both digits as they were. A request that is not allowed changes nothing and raises a one-cycle rejected flag.

Top module: `token_ctr`

## Requirements
- R1: After a synchronous reset every bit inside the five digit fields reads as one. This means D4 is 7 and D3 to D0 are 8. The rejected flag and the pending flag are low.
- R2: D4 occupies addresses 65 to 71. D3, D2, D1 and D0 occupy 72–79, 80–87, 88–95 and 96–103, in that order. At field position k (address minus the field's first address) the read-out is 1 exactly when k is less than the digit value. Addresses outside these ranges read 0.
- R3: A decrement strobe at any address inside a nonzero digit lowers that digit by exactly one. The new pattern is the same whichever position was addressed.
- R4: A decrement on a digit whose value is zero is refused. Nothing changes, and the rejected flag is high in the cycle after the request.
- R5: A borrow strobe at a digit other than D0 sets the next lower digit (the one at higher addresses) to eight. The addressed digit is left unchanged. This is allowed only when the most recent request was an accepted decrement.
- R6: A borrow is refused when the most recent request was not an accepted decrement. A borrow addressed to D0 is always refused.
- R7: A combined strobe at a nonzero digit other than D0 loads a staging register and raises the pending flag. The stored digits stay unchanged until a done pulse. On that done pulse, the addressed digit drops by one and the next lower digit becomes eight, both at the same clock edge.
- R8: An abort while the pending flag is high drops the staged update, and both digits keep their prior values. An abort that arrives in the same cycle as done takes precedence over it.
- R9: A combined strobe is refused at a zero digit or at D0. Every command strobe is refused while an update is pending. Done and abort have no effect when nothing is pending.
- R10: A cycle with more than one command strobe high is refused. So is a command strobe at an address outside the digit fields. Neither changes the stored digits.
- R11: The zero flag is high exactly when the address lies inside a digit field and that digit's value is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_addr | input | 9 | Bit address that selects digit and position |
| dec_req | input | 1 | Single-step decrement strobe |
| ers_req | input | 1 | Borrow (refill next lower digit) strobe |
| cmb_req | input | 1 | Combined decrement-and-borrow strobe |
| cmb_done | input | 1 | Commits the staged combined update |
| cmb_abort | input | 1 | Discards the staged combined update |
| rd_bit | output | 1 | Stored bit at the current address |
| dig_zero | output | 1 | Addressed digit is zero |
| rejected | output | 1 | One-cycle pulse after a refused request |
| commit_pending | output | 1 | A combined update is staged |

## Verification
Two pairs of events can land in the same cycle:
- done and abort while an update is pending;
- a new command strobe together with a done pulse on a pending update.

The bench drives both pairs. It does so in directed cases and through the random mix, which includes a done-plus-abort opcode. In the first pair, abort must win and the digit map must read back unchanged. In the second pair, the new request must be refused while the staged digits still land at that edge. A reference model of the unary digits judges both outcomes through a full sweep of the read-out addresses.

// File: rtl/tc_pkg.sv
package tc_pkg;
    localparam int NUM_DIG = 5;
    localparam int FIELD_W = 8;
    localparam int TOP_W   = 7;
    localparam int ADDR_W  = 9;
    localparam int DIG_IW  = $clog2(NUM_DIG);
    localparam int POS_W   = $clog2(FIELD_W);

    typedef logic [FIELD_W-1:0] field_t;
    typedef field_t [NUM_DIG-1:0] digits_t;

    typedef enum logic [1:0] {OP_NONE, OP_DEC, OP_ERS, OP_CMB} op_e;

    typedef struct packed {
        logic              valid;
        logic [DIG_IW-1:0] dig;
        logic [POS_W-1:0]  pos;
    } sel_t;

    function automatic int field_width(int d);
        return (d == NUM_DIG-1) ? TOP_W : FIELD_W;
    endfunction

    // top digit is read first; lower digits follow at rising addresses
    function automatic int field_start(int base, int d);
        return (d == NUM_DIG-1) ? base : base + TOP_W + (NUM_DIG-2-d)*FIELD_W;
    endfunction

    function automatic field_t full_field(int d);
        field_t f;
        f = '0;
        for (int k = 0; k < FIELD_W; k++)
            if (k < field_width(d)) f[k] = 1'b1;
        return f;
    endfunction

    function automatic digits_t reset_digits();
        digits_t r;
        for (int d = 0; d < NUM_DIG; d++) r[d] = full_field(d);
        return r;
    endfunction
endpackage

// File: rtl/tc_addr_dec.sv
module tc_addr_dec
    import tc_pkg::*;
#(
    parameter int BASE_ADDR = 65
) (
    input  logic [ADDR_W-1:0] addr,
    output sel_t              sel
);
    always_comb begin
        sel = '0;
        for (int d = 0; d < NUM_DIG; d++) begin
            if (int'(addr) >= field_start(BASE_ADDR, d) &&
                int'(addr) <  field_start(BASE_ADDR, d) + field_width(d)) begin
                sel.valid = 1'b1;
                sel.dig   = DIG_IW'(d);
                sel.pos   = POS_W'(int'(addr) - field_start(BASE_ADDR, d));
            end
        end
    end
endmodule

// File: rtl/tc_ops.sv
module tc_ops
    import tc_pkg::*;
(
    input  digits_t digits,
    input  sel_t    sel,
    input  logic    dec_i,
    input  logic    ers_i,
    input  logic    cmb_i,
    input  logic    last_dec_ok,
    input  logic    pending,
    output op_e     op,
    output logic    allow,
    output logic    reject,
    output digits_t nxt
);
    logic [1:0] n_req;
    field_t     cur;
    logic       cur_nonzero;
    logic       not_lowest;

    always_comb begin
        n_req = {1'b0, dec_i} + {1'b0, ers_i} + {1'b0, cmb_i};
        op    = OP_NONE;
        if (n_req == 2'd1)
            op = dec_i ? OP_DEC : (ers_i ? OP_ERS : OP_CMB);

        cur = '0;
        for (int d = 0; d < NUM_DIG; d++)
            if (sel.dig == DIG_IW'(d)) cur = digits[d];
        cur_nonzero = cur[0];
        not_lowest  = (sel.dig != '0);

        unique case (op)
            OP_DEC:  allow = sel.valid & cur_nonzero & ~pending;
            OP_ERS:  allow = sel.valid & not_lowest & last_dec_ok & ~pending;
            OP_CMB:  allow = sel.valid & cur_nonzero & not_lowest & ~pending;
            default: allow = 1'b0;
        endcase
        reject = (n_req != 2'd0) & ~allow;

        nxt = digits;
        for (int d = 0; d < NUM_DIG; d++)
            if (sel.dig == DIG_IW'(d) && op != OP_ERS)
                nxt[d] = digits[d] >> 1;
        for (int d = 0; d < NUM_DIG-1; d++)
            if (sel.dig == DIG_IW'(d+1) && op != OP_DEC)
                nxt[d] = full_field(d);
    end
endmodule

// File: rtl/tc_commit.sv
module tc_commit
    import tc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    load,
    input  digits_t load_data,
    input  logic    done_i,
    input  logic    abort_i,
    output logic    pending,
    output logic    commit_now,
    output digits_t stage
);
    assign commit_now = pending & done_i & ~abort_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
            stage   <= '0;
        end else if (commit_now || (pending && abort_i)) begin
            pending <= 1'b0;
        end else if (load) begin
            pending <= 1'b1;
            stage   <= load_data;
        end
    end
endmodule

// File: rtl/token_ctr.sv
module token_ctr
    import tc_pkg::*;
#(
    parameter int BASE_ADDR = 65
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bit_addr,
    input  logic              dec_req,
    input  logic              ers_req,
    input  logic              cmb_req,
    input  logic              cmb_done,
    input  logic              cmb_abort,
    output logic              rd_bit,
    output logic              dig_zero,
    output logic              rejected,
    output logic              commit_pending
);
    digits_t digits_q;
    digits_t nxt;
    digits_t stage;
    sel_t    sel;
    op_e     op;
    logic    allow;
    logic    reject;
    logic    commit_now;
    logic    last_dec_ok;

    tc_addr_dec #(.BASE_ADDR(BASE_ADDR)) u_dec (
        .addr (bit_addr),
        .sel  (sel)
    );

    tc_ops u_ops (
        .digits      (digits_q),
        .sel         (sel),
        .dec_i       (dec_req),
        .ers_i       (ers_req),
        .cmb_i       (cmb_req),
        .last_dec_ok (last_dec_ok),
        .pending     (commit_pending),
        .op          (op),
        .allow       (allow),
        .reject      (reject),
        .nxt         (nxt)
    );

    tc_commit u_commit (
        .clk        (clk),
        .rst        (rst),
        .load       (allow && op == OP_CMB),
        .load_data  (nxt),
        .done_i     (cmb_done),
        .abort_i    (cmb_abort),
        .pending    (commit_pending),
        .commit_now (commit_now),
        .stage      (stage)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            digits_q    <= reset_digits();
            last_dec_ok <= 1'b0;
            rejected    <= 1'b0;
        end else begin
            rejected <= reject;
            if (commit_now)
                digits_q <= stage;
            else if (allow && op != OP_CMB)
                digits_q <= nxt;
            if (op != OP_NONE || reject)
                last_dec_ok <= allow && (op == OP_DEC);
            else if (commit_now)
                last_dec_ok <= 1'b0;
        end
    end

    always_comb begin
        rd_bit   = 1'b0;
        dig_zero = 1'b0;
        for (int d = 0; d < NUM_DIG; d++) begin
            if (sel.valid && sel.dig == DIG_IW'(d)) begin
                rd_bit   = digits_q[d][sel.pos];
                dig_zero = ~digits_q[d][0];
            end
        end
    end
endmodule

// File: rtl/tc_chk.sv
module tc_chk
    import tc_pkg::*;
(
    input logic    clk,
    input logic    rst,
    input digits_t digits,
    input logic    pend,
    input logic    commit_now,
    input logic    abort_i,
    input logic    rejected,
    input logic    dig_zero,
    input logic    rd_bit
);
    // R4
    rej_keeps_state_chk: assert property (@(posedge clk) disable iff (rst)
        rejected && !$past(commit_now) |-> digits == $past(digits));

    // R7
    pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
        pend && !commit_now |=> $stable(digits));

    // R7
    commit_clears_chk: assert property (@(posedge clk) disable iff (rst)
        commit_now |=> !pend);

    // R8
    abort_discard_chk: assert property (@(posedge clk) disable iff (rst)
        pend && abort_i |=> !pend && $stable(digits));

    // R11
    zero_reads_low_chk: assert property (@(posedge clk) disable iff (rst)
        dig_zero |-> !rd_bit);

    for (genvar d = 0; d < NUM_DIG; d++) begin : g_shape
        // R2
        unary_shape_chk: assert property (@(posedge clk) disable iff (rst)
            ((digits[d] & field_t'(digits[d] + field_t'(1))) == '0) &&
            ((digits[d] & ~full_field(d)) == '0));
    end
endmodule

bind token_ctr tc_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .digits     (digits_q),
    .pend       (commit_pending),
    .commit_now (commit_now),
    .abort_i    (cmb_abort),
    .rejected   (rejected),
    .dig_zero   (dig_zero),
    .rd_bit     (rd_bit)
);

// File: tb/token_ctr_tb.sv
`timescale 1ns/1ps
module token_ctr_tb;
    localparam int CLK_NS = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [8:0] bit_addr = '0;
    logic       dec_req = 0, ers_req = 0, cmb_req = 0, cmb_done = 0, cmb_abort = 0;
    logic       rd_bit, dig_zero, rejected, commit_pending;

    int checks = 0;
    int errors = 0;
    int exp_v[5];
    int exp_stage[5];
    bit exp_pend;
    bit exp_last;

    always #(CLK_NS/2) clk = ~clk;

    token_ctr u_dut (
        .clk(clk), .rst(rst), .bit_addr(bit_addr),
        .dec_req(dec_req), .ers_req(ers_req), .cmb_req(cmb_req),
        .cmb_done(cmb_done), .cmb_abort(cmb_abort),
        .rd_bit(rd_bit), .dig_zero(dig_zero), .rejected(rejected),
        .commit_pending(commit_pending)
    );

    function automatic void decode(input int a, output bit v, output int d, output int p);
        v = 0; d = 0; p = 0;
        if (a >= 65 && a <= 71) begin
            v = 1; d = 4; p = a - 65;
        end else if (a >= 72 && a <= 103) begin
            v = 1; d = 3 - (a - 72) / 8; p = (a - 72) % 8;
        end
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic reset_model();
        for (int d = 0; d < 5; d++) exp_v[d] = (d == 4) ? 7 : 8;
        exp_pend = 0;
        exp_last = 0;
    endtask

    // full sweep of read-out bits and zero flag; one check per sweep
    task automatic check_map(input string tag);
        int bad_a = -1, act = 0, exp = 0;
        for (int a = 60; a <= 108; a++) begin
            bit v; int d, p; bit eb, ez;
            decode(a, v, d, p);
            eb = v && (p < exp_v[d]);
            ez = v && (exp_v[d] == 0);
            bit_addr = 9'(a);
            #1;
            if (bad_a < 0 && (rd_bit !== eb || dig_zero !== ez)) begin
                bad_a = a; act = {rd_bit, dig_zero}; exp = {eb, ez};
            end
        end
        checks++;
        if (bad_a >= 0) begin
            errors++;
            $display("FAIL %s map at addr %0d actual={bit,zero}=%0d expected=%0d", tag, bad_a, act, exp);
        end
    endtask

    task automatic apply(input int a, input bit dc, input bit er, input bit cm,
                         input bit dn, input bit ab, input string tag);
        int n; bit v; int d, p; bit acc, rej;
        @(negedge clk);
        bit_addr = 9'(a);
        dec_req = dc; ers_req = er; cmb_req = cm; cmb_done = dn; cmb_abort = ab;
        n = dc + er + cm;
        decode(a, v, d, p);
        acc = 0;
        if (n == 1) begin
            if (dc) acc = v && exp_v[d] > 0 && !exp_pend;
            if (er) acc = v && d > 0 && exp_last && !exp_pend;
            if (cm) acc = v && d > 0 && exp_v[d] > 0 && !exp_pend;
        end
        rej = (n > 0) && !acc;
        if (exp_pend && dn && !ab) begin
            for (int i = 0; i < 5; i++) exp_v[i] = exp_stage[i];
            exp_pend = 0;
            exp_last = 0;
        end else if (exp_pend && ab) begin
            exp_pend = 0;
        end
        if (n > 0) exp_last = acc && dc;
        if (acc && dc) exp_v[d]--;
        if (acc && er) exp_v[d-1] = 8;
        if (acc && cm) begin
            for (int i = 0; i < 5; i++) exp_stage[i] = exp_v[i];
            exp_stage[d]--;
            exp_stage[d-1] = 8;
            exp_pend = 1;
        end
        @(negedge clk);
        dec_req = 0; ers_req = 0; cmb_req = 0; cmb_done = 0; cmb_abort = 0;
        check({tag, " rejected"}, rejected, rej);
        check({tag, " pending"}, commit_pending, exp_pend);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_NS * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        reset_model();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 rejected", rejected, 0);
        check("R1 pending", commit_pending, 0);
        check_map("R1 R2 reset map");

        // R6 borrow without a preceding decrement
        apply(82, 0, 1, 0, 0, 0, "R6 borrow no prior dec");
        // R3 decrement at different positions of D0
        apply(101, 1, 0, 0, 0, 0, "R3 dec D0 pos5");
        apply(96, 1, 0, 0, 0, 0, "R3 dec D0 pos0");
        check_map("R3 D0 pattern");
        // R6 borrow at lowest digit after accepted decrement
        apply(99, 0, 1, 0, 0, 0, "R6 borrow D0");
        // R5 decrement D1 then borrow refills D0
        apply(93, 1, 0, 0, 0, 0, "R5 dec D1");
        apply(90, 0, 1, 0, 0, 0, "R5 borrow D1");
        check_map("R5 D0 refilled");

        // R4 drain D4 then decrement a zero digit
        for (int i = 0; i < 7; i++) apply(65 + i, 1, 0, 0, 0, 0, "R3 drain D4");
        bit_addr = 9'd68; #1;
        check("R11 zero flag D4", dig_zero, 1);
        check("R11 zero read D4", rd_bit, 0);
        apply(70, 1, 0, 0, 0, 0, "R4 dec zero D4");
        check_map("R4 map after refuse");
        // R9 combined at zero digit and at lowest digit
        apply(66, 0, 0, 1, 0, 0, "R9 cmb zero D4");
        apply(100, 0, 0, 1, 0, 0, "R9 cmb D0");

        // R7 combined at D3 with D2 lowered first
        apply(84, 1, 0, 0, 0, 0, "R7 prep D2");
        apply(85, 1, 0, 0, 0, 0, "R7 prep D2");
        apply(75, 0, 0, 1, 0, 0, "R7 cmb D3");
        check_map("R7 staged not visible");
        apply(80, 1, 0, 0, 0, 0, "R9 dec while pending");
        apply(75, 0, 0, 0, 1, 0, "R7 done commits");
        check_map("R7 after commit");
        // R8 abort and done in the same cycle
        apply(87, 0, 0, 1, 0, 0, "R8 cmb D2");
        apply(87, 0, 0, 0, 1, 1, "R8 done+abort");
        check_map("R8 unchanged");
        // request together with done while pending
        apply(90, 0, 0, 1, 0, 0, "R7 cmb D1");
        apply(90, 1, 0, 0, 1, 0, "R9 req with done");
        check_map("R7 commit with refused req");
        // R9 done and abort with nothing pending
        apply(90, 0, 0, 0, 1, 0, "R9 idle done");
        apply(90, 0, 0, 0, 0, 1, "R9 idle abort");
        // R10 multiple strobes and out-of-range address
        apply(90, 1, 1, 0, 0, 0, "R10 two strobes");
        apply(64, 1, 0, 0, 0, 0, "R10 out of range");
        apply(104, 0, 0, 1, 0, 0, "R10 out of range cmb");
        check_map("R10 map");

        // random mix
        for (int it = 0; it < 400; it++) begin
            int k = $urandom_range(0, 9);
            int a = $urandom_range(62, 106);
            case (k)
                0, 1, 2: apply(a, 1, 0, 0, 0, 0, "R3 R4 rnd dec");
                3, 4:    apply(a, 0, 1, 0, 0, 0, "R5 R6 rnd borrow");
                5:       apply(a, 0, 0, 1, 0, 0, "R7 R9 rnd cmb");
                6:       apply(a, 0, 0, 0, 1, 0, "R7 rnd done");
                7:       apply(a, 0, 0, 0, 0, 1, "R8 rnd abort");
                8:       apply(a, 0, 0, 0, 1, 1, "R8 rnd done+abort");
                default: apply(a, 1, 1, 0, 0, 0, "R10 rnd multi");
            endcase
            if (it % 20 == 19) check_map("R2 R11 rnd map");
        end
        check_map("R2 final map");
        finish_run();
    end
endmodule